// File: doc/BRIEF.md
# Floating-Point Error Reporting Gate

This block sits between the floating-point instruction issue point and the rest of a core. It holds a single flag for an unmasked numeric error that has not yet been handled. It uses that flag to decide, one instruction at a time, whether the next floating-point operation may start. A registered active-low status pin tells external logic that an error is outstanding. An active-low ignore input lets external logic release stalled instructions while the error stays recorded.

A control bit chooses how errors are delivered. With the bit clear, errors appear on the status pin, and waiting instructions stall until the error is cleared or the ignore input is asserted. With the bit set, the pin stays quiet and the ignore input is disregarded. Instead, the next waiting instruction is turned into a one-cycle internal exception request. A small set of non-waiting control operations always passes, because software needs them to inspect and clear the error state. Two of those operations also clear the flag.

Every decision is registered. A verdict for an operation presented in one cycle appears on the outputs in the next cycle.

Top module: `fpe_gate`

## Requirements
- R1: After synchronous reset, `ferr_n` is 1, the pending flag is clear, and `op_allow`, `op_stall` and `int_exc_req` are 0.
- R2: With `nume_en`=0, an error event with `err_masked`=0 sets the pending flag, and `ferr_n` reads 0 in the cycle after the event. It stays 0 until the flag is cleared.
- R3: An error event with `err_masked`=1 changes no pending state and never drives `ferr_n` low.
- R4: With no error pending, every presented operation (`op_valid`=1) gets `op_allow`=1 in the next cycle, whatever its class.
- R5: While an error is pending, with `nume_en`=0 and `ignore_n`=1, only class codes 1 to 6 are allowed. These are 1 clear-exceptions, 2 initialize, 3 save-state, 4 store-control, 5 store-environment and 6 store-status. Any other code (0, 7 to 15) gets `op_stall`=1 and `op_allow`=0 in the next cycle.
- R6: With `nume_en`=0 and `ignore_n`=0, every presented operation is allowed despite a pending error. The flag stays set and `ferr_n` stays 0.
- R7: With `nume_en`=1, `ignore_n` has no effect and `ferr_n` stays 1. A pending error turns a non-whitelisted operation into `int_exc_req`=1 for exactly the next cycle, with `op_allow`=0 and `op_stall`=0.
- R8: An operation of class 1 or 2 clears the pending flag, so `ferr_n` returns to 1 the cycle after it. Classes 3 to 6 do not clear it. An unmasked error in the same cycle as a clearing operation leaves the flag set.
- R9: After reset, `ferr_n` always drives a defined 0 or 1 and never floats. At most one of `op_allow`, `op_stall` and `int_exc_req` is 1 in any cycle.
- R10: In a cycle after one with `op_valid`=0, `op_allow`, `op_stall` and `int_exc_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_valid | input | 1 | Floating-point error event this cycle |
| err_masked | input | 1 | The error event is masked |
| op_valid | input | 1 | A floating-point operation is presented |
| op_class | input | CLASS_W | Class code of the presented operation |
| ignore_n | input | 1 | Active-low ignore-error input |
| nume_en | input | 1 | 1 selects internal error reporting, 0 selects the pin |
| ferr_n | output | 1 | Active-low pending-error status, registered |
| op_allow | output | 1 | Verdict: the operation may execute |
| op_stall | output | 1 | Verdict: the operation must wait |
| int_exc_req | output | 1 | Verdict: raise an internal numeric exception |

## Verification
The assertions check the following on every cycle: setting and clearing of the flag, the masked-error rule, that the three verdicts are mutually exclusive and quiet when idle, and that the pin is never undefined. They also check that a waiting operation is routed to a stall, an allow or an exception as the ignore input and the enable bit require. Only the bench's scenarios show the full whitelist under a pending error, and that the save and store classes leave the flag set. The same holds for an error that coincides with a clear, and for the pin following the enable bit when it is switched with an error outstanding.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

  // Operation class codes. Whitelist membership and clearing are set by
  // parameter masks at the top; these names serve documentation and the bench.
  localparam int unsigned CLS_ARITH  = 0;
  localparam int unsigned CLS_CLREX  = 1;
  localparam int unsigned CLS_INIT   = 2;
  localparam int unsigned CLS_SAVE   = 3;
  localparam int unsigned CLS_STCTL  = 4;
  localparam int unsigned CLS_STENV  = 5;
  localparam int unsigned CLS_STSTAT = 6;

  typedef struct packed {
    logic allow;
    logic stall;
    logic exc;
  } verdict_t;

endpackage

// File: rtl/fpe_class_decode.sv
module fpe_class_decode #(
  parameter int unsigned CLASS_W  = 4,
  parameter int unsigned NUM_CLS  = 1 << CLASS_W,
  parameter logic [NUM_CLS-1:0] WL_MASK  = '0,
  parameter logic [NUM_CLS-1:0] CLR_MASK = '0
) (
  input  logic               op_valid,
  input  logic [CLASS_W-1:0] op_class,
  output logic               is_whitelist,
  output logic               is_clear
);

  logic [NUM_CLS-1:0] hit;

  for (genvar i = 0; i < NUM_CLS; i++) begin : g_hit
    assign hit[i] = (op_class == CLASS_W'(i));
  end

  assign is_whitelist = |(hit & WL_MASK);
  assign is_clear     = op_valid & (|(hit & CLR_MASK));

endmodule

// File: rtl/fpe_pending_tracker.sv
module fpe_pending_tracker (
  input  logic clk,
  input  logic rst,
  input  logic err_valid,
  input  logic err_masked,
  input  logic clear,
  input  logic nume_en,
  output logic pending,
  output logic ferr_n
);

  logic pending_q, pending_d, ferr_n_q, err_set;

  assign err_set   = err_valid & ~err_masked;
  // A fresh error wins over a clear in the same cycle.
  assign pending_d = (pending_q & ~clear) | err_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b0;
      ferr_n_q  <= 1'b1;
    end else begin
      pending_q <= pending_d;
      ferr_n_q  <= ~(pending_d & ~nume_en);
    end
  end

  assign pending = pending_q;
  assign ferr_n  = ferr_n_q;

  assert_set_R2: assert property (@(posedge clk) disable iff (rst)
    (err_valid && !err_masked) |=> pending_q);

  assert_masked_R3: assert property (@(posedge clk) disable iff (rst)
    (err_valid && err_masked && !pending_q) |=> !pending_q);

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (clear && !(err_valid && !err_masked)) |=> (!pending_q && ferr_n_q));

  assert_pin_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    nume_en |=> ferr_n_q);

  assert_ferr_known_R9: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(ferr_n_q));

endmodule

// File: rtl/fpe_issue_ctrl.sv
module fpe_issue_ctrl
  import fpe_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     op_valid,
  input  logic     is_whitelist,
  input  logic     pending,
  input  logic     ignore_n,
  input  logic     nume_en,
  output verdict_t verdict
);

  verdict_t v_d, v_q;
  logic     ign_eff, blocked;

  assign ign_eff = ~ignore_n & ~nume_en;
  assign blocked = pending & ~is_whitelist & ~ign_eff;

  always_comb begin
    v_d       = '0;
    v_d.allow = op_valid & ~blocked;
    v_d.stall = op_valid & blocked & ~nume_en;
    v_d.exc   = op_valid & blocked & nume_en;
  end

  always_ff @(posedge clk) begin
    if (rst) v_q <= '0;
    else     v_q <= v_d;
  end

  assign verdict = v_q;

  assert_free_R4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !pending) |=> v_q.allow);

  assert_stall_R5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && pending && !is_whitelist && !nume_en && ignore_n) |=> (v_q.stall && !v_q.allow));

  assert_ignore_R6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !ignore_n && !nume_en) |=> v_q.allow);

  assert_exc_R7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && pending && !is_whitelist && nume_en) |=> (v_q.exc && !v_q.stall && !v_q.allow));

  assert_excl_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({v_q.allow, v_q.stall, v_q.exc}));

  assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (v_q == '0));

endmodule

// File: rtl/fpe_gate.sv
module fpe_gate
  import fpe_pkg::*;
#(
  parameter int unsigned CLASS_W = 4,
  parameter int unsigned NUM_CLS = 1 << CLASS_W,
  parameter logic [NUM_CLS-1:0] WL_MASK  = NUM_CLS'(16'b0000_0000_0111_1110),
  parameter logic [NUM_CLS-1:0] CLR_MASK = NUM_CLS'(16'b0000_0000_0000_0110)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               err_valid,
  input  logic               err_masked,
  input  logic               op_valid,
  input  logic [CLASS_W-1:0] op_class,
  input  logic               ignore_n,
  input  logic               nume_en,
  output logic               ferr_n,
  output logic               op_allow,
  output logic               op_stall,
  output logic               int_exc_req
);

  logic     is_wl, is_clr, pending;
  verdict_t verdict;

  fpe_class_decode #(
    .CLASS_W (CLASS_W),
    .NUM_CLS (NUM_CLS),
    .WL_MASK (WL_MASK),
    .CLR_MASK(CLR_MASK)
  ) u_decode (
    .op_valid    (op_valid),
    .op_class    (op_class),
    .is_whitelist(is_wl),
    .is_clear    (is_clr)
  );

  fpe_pending_tracker u_track (
    .clk       (clk),
    .rst       (rst),
    .err_valid (err_valid),
    .err_masked(err_masked),
    .clear     (is_clr),
    .nume_en   (nume_en),
    .pending   (pending),
    .ferr_n    (ferr_n)
  );

  fpe_issue_ctrl u_issue (
    .clk         (clk),
    .rst         (rst),
    .op_valid    (op_valid),
    .is_whitelist(is_wl),
    .pending     (pending),
    .ignore_n    (ignore_n),
    .nume_en     (nume_en),
    .verdict     (verdict)
  );

  assign op_allow    = verdict.allow;
  assign op_stall    = verdict.stall;
  assign int_exc_req = verdict.exc;

endmodule

// File: tb/test_fpe_gate.sv
module test_fpe_gate;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       err_valid = 0, err_masked = 0, op_valid = 0;
  logic [3:0] op_class = 0;
  logic       ignore_n = 1, nume_en = 0;
  logic       ferr_n, op_allow, op_stall, int_exc_req;

  fpe_gate i_fpe_gate (
    .clk(clk), .rst(rst), .err_valid(err_valid), .err_masked(err_masked),
    .op_valid(op_valid), .op_class(op_class), .ignore_n(ignore_n),
    .nume_en(nume_en), .ferr_n(ferr_n), .op_allow(op_allow),
    .op_stall(op_stall), .int_exc_req(int_exc_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int unsigned due;
    logic [3:0]  exp;   // {ferr_n, allow, stall, exc}
    string       tag;
  } item_t;

  item_t       sb[$];
  int unsigned cyc = 0;
  int          total = 0, fails = 0;
  bit          model_pend = 0;
  bit          done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares results at the falling edge after the registering edge.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      item_t it;
      logic [3:0] act;
      it  = sb.pop_front();
      act = {ferr_n, op_allow, op_stall, int_exc_req};
      total++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: {ferr_n,allow,stall,exc} actual=%b expected=%b", it.tag, act, it.exp);
      end
      total++;  // R9: defined pin and exclusive verdicts
      if ($isunknown(ferr_n) || !$onehot0({op_allow, op_stall, int_exc_req})) begin
        fails++;
        $display("FAIL R9 (%s): actual=%b expected defined pin, one verdict", it.tag, act);
      end
    end
  end

  // Driver: presents one cycle of stimulus and queues the expected result.
  task automatic step(input bit ev, input bit msk, input bit ov, input int cls,
                      input bit ign_n, input bit ne, input string tag);
    bit wl, ign_eff, clr, nxt, a, s, e, f;
    item_t it;
    @(negedge clk);
    err_valid = ev; err_masked = msk; op_valid = ov; op_class = 4'(cls);
    ignore_n = ign_n; nume_en = ne;
    wl      = (cls >= 1 && cls <= 6);
    ign_eff = !ign_n && !ne;
    a   = ov && (!model_pend || wl || ign_eff);
    s   = ov && model_pend && !wl && !ign_eff && !ne;
    e   = ov && model_pend && !wl && ne;
    clr = ov && (cls == 1 || cls == 2);
    nxt = (model_pend && !clr) || (ev && !msk);
    f   = !(nxt && !ne);
    model_pend = nxt;
    it.due = cyc + 1;
    it.exp = {f, a, s, e};
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input bit ne, input string tag);
    step(0, 0, 0, 0, 1, ne, tag);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    total++;  // R1 reset state
    if ({ferr_n, op_allow, op_stall, int_exc_req} !== 4'b1000) begin
      fails++;
      $display("FAIL R1: actual=%b expected=1000", {ferr_n, op_allow, op_stall, int_exc_req});
    end
    idle(0, "R1");
    step(0, 0, 1, 0, 1, 0, "R4");
    step(0, 0, 1, 9, 1, 0, "R4");
    // R3 masked error
    step(1, 1, 0, 0, 1, 0, "R3");
    step(0, 0, 1, 0, 1, 0, "R3");
    idle(0, "R10");
    // R2 unmasked error, pin low and held
    step(1, 0, 1, 0, 1, 0, "R2");
    idle(0, "R2");
    idle(0, "R2");
    // R5 stall of waiting classes, whitelist passes, no clear from 3..6
    step(0, 0, 1, 0, 1, 0, "R5");
    step(0, 0, 1, 7, 1, 0, "R5");
    step(0, 0, 1, 15, 1, 0, "R5");
    for (int c = 3; c <= 6; c++) step(0, 0, 1, c, 1, 0, "R5");
    idle(0, "R8");
    // R6 ignore input releases the stall, flag kept
    step(0, 0, 1, 0, 0, 0, "R6");
    step(0, 0, 1, 8, 0, 0, "R6");
    step(0, 0, 1, 0, 1, 0, "R6");
    // R8 clear-exceptions clears
    step(0, 0, 1, 1, 1, 0, "R8");
    step(0, 0, 1, 0, 1, 0, "R8");
    // R8 initialize clears
    step(1, 0, 0, 0, 1, 0, "R8");
    step(0, 0, 1, 2, 1, 0, "R8");
    step(0, 0, 1, 0, 1, 0, "R8");
    // R8 error coincides with clear: flag stays
    step(1, 0, 1, 1, 1, 0, "R8");
    step(0, 0, 1, 0, 1, 0, "R8");
    step(0, 0, 1, 2, 1, 0, "R8");
    // R7 internal reporting
    idle(1, "R7");
    step(1, 0, 0, 0, 1, 1, "R7");
    step(0, 0, 1, 0, 0, 1, "R7");
    idle(1, "R7");
    step(0, 0, 1, 12, 1, 1, "R7");
    step(0, 0, 1, 4, 1, 1, "R7");
    idle(0, "R2");
    step(0, 0, 1, 0, 1, 0, "R5");
    step(0, 0, 1, 1, 1, 1, "R7");
    step(0, 0, 1, 0, 0, 1, "R7");
    idle(0, "R10");
    idle(0, "R10");
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule